// File: doc/BRIEF.md
# Bufferless Deflection Mesh Router

This block is one node of a two-dimensional mesh in which routers keep no input queues. Each cycle up to four flits arrive from the neighbouring routers on the north, east, south and west links. They are held for one cycle in a pipeline latch and must all leave on the next cycle. Each flit asks for the one output that moves it toward its destination, X dimension first and then Y. When several flits want the same output, the oldest one takes it. The others are sent out on whatever network outputs remain free, and their age field is raised by one. A flit that has reached this node's coordinates leaves on the local ejection port. Only one flit can eject per cycle, so any other flit at home is also misrouted.

The local node offers one new flit per cycle. The flit is taken only if a network output is still unused after every in-flight flit has been placed. Acceptance is reported in the same cycle, so the node can hold the flit and offer it again. The node's own coordinates and all field widths are parameters.

Top module: `rdr_deflect_router`

## Requirements
- R1: A flit is packed, from most to least significant bit, as destination X (X_W bits), destination Y (Y_W bits), age (AGE_W bits) and payload (PAY_W bits). Network port numbers are north 0, east 1, south 2 and west 3. Each flit has one desired output: east if its X is above MY_X, west if its X is below MY_X, otherwise north if its Y is above MY_Y, south if its Y is below MY_Y, and otherwise local ejection. An uncontested flit leaves on its desired output.
- R2: A flit that is valid on a network input at clock edge t appears on exactly one output (network or ejection) right after edge t+1. No flit is dropped or duplicated, and no output is valid without a source.
- R3: When flits compete for the same output, the one with the larger age wins. Equal ages go to the lower input port number. The injected flit always has the lowest priority.
- R4: A flit whose destination equals (MY_X, MY_Y) leaves on the ejection port, at most one per cycle. The ejection port only ever carries flits addressed to this node.
- R5: inj_accept is high in the cycle, with no register in between, when inj_valid is high and a network output is left unused by the latched flits. An accepted flit takes its desired network output if that output is free, and otherwise the lowest-numbered free network output. It appears on that output after the next edge.
- R6: A flit that loses its desired output is placed, in priority order, on the lowest-numbered network output still free after all desired-output grants are made.
- R7: A flit placed on an output other than its desired one has its age raised by one, saturating at the maximum value. A flit that gets its desired output keeps its age. Payload and destination never change.
- R8: During synchronous reset, and on the first cycle after it, every output is invalid. inj_accept is held low while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Flit present on network inputs N, E, S, W |
| in_flit | input | 4 x FLIT_W | Arriving flits, one per network input |
| inj_valid | input | 1 | Local node offers a flit |
| inj_flit | input | FLIT_W | Flit offered by the local node |
| inj_accept | output | 1 | Offered flit is taken this cycle |
| out_valid | output | 4 | Flit leaving on network outputs N, E, S, W |
| out_flit | output | 4 x FLIT_W | Departing flits |
| ej_valid | output | 1 | Flit ejected to the local node |
| ej_flit | output | FLIT_W | Ejected flit |

## Verification
The in-line properties assume that each input carries at most one flit per cycle. They also assume the local node never offers a flit addressed to this same node and that inj_valid is low while reset is applied. The bench keeps within these limits: it draws injected destinations only from coordinates other than the node's own and holds inj_valid low across reset release, except for one deliberate check while reset is high. Stimulus comes from a deterministic pseudo-random sweep over all destination pairs of the 4x4 mesh. Ages are limited to a small range so that ties and saturation occur often. Directed cases add full four-way contention for one output, two flits ejecting at once, saturated ages and injection into a full router.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
   localparam int unsigned NET_PORTS = 4;
   localparam int unsigned ALL_PORTS = NET_PORTS + 1;
   localparam int unsigned PSEL_W    = 3;

   localparam logic [PSEL_W-1:0] PORT_N = 3'd0;
   localparam logic [PSEL_W-1:0] PORT_E = 3'd1;
   localparam logic [PSEL_W-1:0] PORT_S = 3'd2;
   localparam logic [PSEL_W-1:0] PORT_W = 3'd3;
   localparam logic [PSEL_W-1:0] PORT_L = 3'd4;
endpackage

// File: rtl/rdr_route.sv
module rdr_route
   import rdr_pkg::*;
#(
   parameter int unsigned X_W  = 2,
   parameter int unsigned Y_W  = 2,
   parameter int unsigned MY_X = 1,
   parameter int unsigned MY_Y = 2
) (
   input  logic [X_W-1:0]    dst_x,
   input  logic [Y_W-1:0]    dst_y,
   output logic [PSEL_W-1:0] want
);
   localparam logic [X_W-1:0] HOME_X = X_W'(MY_X);
   localparam logic [Y_W-1:0] HOME_Y = Y_W'(MY_Y);

   // X dimension is resolved before Y
   always_comb begin
      if (dst_x > HOME_X)      want = PORT_E;
      else if (dst_x < HOME_X) want = PORT_W;
      else if (dst_y > HOME_Y) want = PORT_N;
      else if (dst_y < HOME_Y) want = PORT_S;
      else                     want = PORT_L;
   end
endmodule

// File: rtl/rdr_rank.sv
module rdr_rank
   import rdr_pkg::*;
#(
   parameter int unsigned AGE_W = 3
) (
   input  logic [NET_PORTS-1:0]             req_v,
   input  logic [NET_PORTS-1:0][AGE_W-1:0]  req_age,
   output logic [NET_PORTS-1:0][PSEL_W-1:0] req_rank
);
   // rank = number of valid flits that beat this one
   for (genvar i = 0; i < NET_PORTS; i++) begin : g_rank
      logic [PSEL_W-1:0] beaten_by;
      always_comb begin
         beaten_by = '0;
         for (int j = 0; j < NET_PORTS; j++) begin
            if (j != i && req_v[j]) begin
               if (req_age[j] > req_age[i] ||
                   (req_age[j] == req_age[i] && j < i))
                  beaten_by = beaten_by + 1'b1;
            end
         end
      end
      assign req_rank[i] = beaten_by;
   end
endmodule

// File: rtl/rdr_alloc.sv
module rdr_alloc
   import rdr_pkg::*;
(
   input  logic [NET_PORTS-1:0]             req_v,
   input  logic [NET_PORTS-1:0][PSEL_W-1:0] req_want,
   input  logic [NET_PORTS-1:0][PSEL_W-1:0] req_rank,
   input  logic                             inj_v,
   input  logic [PSEL_W-1:0]                inj_want,
   output logic [NET_PORTS-1:0][PSEL_W-1:0] grant_port,
   output logic [NET_PORTS-1:0]             grant_defl,
   output logic [PSEL_W-1:0]                inj_port,
   output logic                             inj_ok,
   output logic                             inj_defl
);
   logic [7:0]           taken;
   logic [NET_PORTS-1:0] placed;

   always_comb begin
      taken      = '0;
      placed     = '0;
      grant_port = '0;
      grant_defl = '0;
      inj_port   = '0;
      inj_ok     = 1'b0;
      inj_defl   = 1'b0;

      // pass 1: desired outputs, oldest first
      for (int r = 0; r < NET_PORTS; r++) begin
         for (int i = 0; i < NET_PORTS; i++) begin
            if (req_v[i] && req_rank[i] == PSEL_W'(r) && !taken[req_want[i]]) begin
               taken[req_want[i]] = 1'b1;
               grant_port[i]      = req_want[i];
               placed[i]          = 1'b1;
            end
         end
      end

      // pass 2: losers take lowest free network output, in priority order
      for (int r = 0; r < NET_PORTS; r++) begin
         for (int i = 0; i < NET_PORTS; i++) begin
            if (req_v[i] && req_rank[i] == PSEL_W'(r) && !placed[i]) begin
               for (int p = 0; p < NET_PORTS; p++) begin
                  if (!placed[i] && !taken[p]) begin
                     taken[p]      = 1'b1;
                     grant_port[i] = PSEL_W'(p);
                     grant_defl[i] = 1'b1;
                     placed[i]     = 1'b1;
                  end
               end
            end
         end
      end

      // injection uses whatever is left
      if (inj_v) begin
         if (inj_want != PORT_L && !taken[inj_want]) begin
            inj_ok   = 1'b1;
            inj_port = inj_want;
         end else begin
            for (int p = 0; p < NET_PORTS; p++) begin
               if (!inj_ok && !taken[p]) begin
                  inj_ok   = 1'b1;
                  inj_port = PSEL_W'(p);
                  inj_defl = 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/rdr_deflect_router.sv
module rdr_deflect_router
   import rdr_pkg::*;
#(
   parameter int unsigned X_W   = 2,
   parameter int unsigned Y_W   = 2,
   parameter int unsigned AGE_W = 3,
   parameter int unsigned PAY_W = 8,
   parameter int unsigned MY_X  = 1,
   parameter int unsigned MY_Y  = 2,
   localparam int unsigned FLIT_W = X_W + Y_W + AGE_W + PAY_W
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NET_PORTS-1:0]             in_valid,
   input  logic [NET_PORTS-1:0][FLIT_W-1:0] in_flit,
   input  logic                             inj_valid,
   input  logic [FLIT_W-1:0]                inj_flit,
   output logic                             inj_accept,
   output logic [NET_PORTS-1:0]             out_valid,
   output logic [NET_PORTS-1:0][FLIT_W-1:0] out_flit,
   output logic                             ej_valid,
   output logic [FLIT_W-1:0]                ej_flit
);
   localparam int unsigned AGE_LO = PAY_W;
   localparam int unsigned AGE_HI = PAY_W + AGE_W - 1;
   localparam int unsigned DY_LO  = AGE_HI + 1;
   localparam int unsigned DY_HI  = DY_LO + Y_W - 1;
   localparam int unsigned DX_LO  = DY_HI + 1;
   localparam int unsigned DX_HI  = FLIT_W - 1;

   initial begin
      if (X_W < 1 || Y_W < 1 || AGE_W < 1 || PAY_W < 1)
         $error("rdr_deflect_router: every field width must be at least 1");
      if (MY_X >= (1 << X_W) || MY_Y >= (1 << Y_W))
         $error("rdr_deflect_router: node coordinate does not fit its field");
   end

   // pipeline latches: the only storage a flit sees inside the router
   logic [NET_PORTS-1:0]             lat_v;
   logic [NET_PORTS-1:0][FLIT_W-1:0] lat_f;

   always_ff @(posedge clk) begin
      if (rst) begin
         lat_v <= '0;
         lat_f <= '0;
      end else begin
         lat_v <= in_valid;
         lat_f <= in_flit;
      end
   end

   // candidates: index NET_PORTS is the local injector
   logic [NET_PORTS:0][FLIT_W-1:0] cand_f;
   logic [NET_PORTS:0][PSEL_W-1:0] cand_want;
   logic [NET_PORTS-1:0][AGE_W-1:0] lat_age;

   assign cand_f[NET_PORTS] = inj_flit;

   for (genvar g = 0; g <= NET_PORTS; g++) begin : g_cand
      if (g < NET_PORTS) begin : g_net
         assign cand_f[g]  = lat_f[g];
         assign lat_age[g] = lat_f[g][AGE_HI:AGE_LO];
      end
      rdr_route #(
         .X_W  (X_W),
         .Y_W  (Y_W),
         .MY_X (MY_X),
         .MY_Y (MY_Y)
      ) u_route (
         .dst_x (cand_f[g][DX_HI:DX_LO]),
         .dst_y (cand_f[g][DY_HI:DY_LO]),
         .want  (cand_want[g])
      );
   end

   logic [NET_PORTS-1:0][PSEL_W-1:0] lat_rank;

   rdr_rank #(.AGE_W(AGE_W)) u_rank (
      .req_v    (lat_v),
      .req_age  (lat_age),
      .req_rank (lat_rank)
   );

   logic [NET_PORTS-1:0][PSEL_W-1:0] grant_port;
   logic [NET_PORTS-1:0]             grant_defl;
   logic [PSEL_W-1:0]                inj_port;
   logic                             inj_ok;
   logic                             inj_defl;
   logic                             inj_go;

   rdr_alloc u_alloc (
      .req_v      (lat_v),
      .req_want   (cand_want[NET_PORTS-1:0]),
      .req_rank   (lat_rank),
      .inj_v      (inj_valid & ~rst),
      .inj_want   (cand_want[NET_PORTS]),
      .grant_port (grant_port),
      .grant_defl (grant_defl),
      .inj_port   (inj_port),
      .inj_ok     (inj_ok),
      .inj_defl   (inj_defl)
   );

   assign inj_go     = inj_ok & inj_valid & ~rst;
   assign inj_accept = inj_go;

   function automatic logic [FLIT_W-1:0] age_bump(input logic [FLIT_W-1:0] f,
                                                  input logic bump);
      logic [FLIT_W-1:0] r;
      r = f;
      if (bump && f[AGE_HI:AGE_LO] != {AGE_W{1'b1}})
         r[AGE_HI:AGE_LO] = f[AGE_HI:AGE_LO] + 1'b1;
      return r;
   endfunction

   logic [7:0]             nxt_v;
   logic [7:0][FLIT_W-1:0] nxt_f;

   always_comb begin
      nxt_v = '0;
      nxt_f = '0;
      for (int i = 0; i < NET_PORTS; i++) begin
         if (lat_v[i]) begin
            nxt_v[grant_port[i]] = 1'b1;
            nxt_f[grant_port[i]] = age_bump(lat_f[i], grant_defl[i]);
         end
      end
      if (inj_go) begin
         nxt_v[inj_port] = 1'b1;
         nxt_f[inj_port] = age_bump(inj_flit, inj_defl);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= '0;
         out_flit  <= '0;
         ej_valid  <= 1'b0;
         ej_flit   <= '0;
      end else begin
         out_valid <= nxt_v[NET_PORTS-1:0];
         out_flit  <= nxt_f[NET_PORTS-1:0];
         ej_valid  <= nxt_v[PORT_L];
         ej_flit   <= nxt_f[PORT_L];
      end
   end

   // flits counted in must equal flits counted out one cycle later
   AST_NO_DROP: assert property (@(posedge clk) disable iff (rst)
      $countones({ej_valid, out_valid}) ==
      $countones($past(lat_v)) + int'($past(inj_accept))); // R2

   AST_NO_GHOST: assert property (@(posedge clk) disable iff (rst)
      (lat_v == '0 && !inj_accept) |=> ({ej_valid, out_valid} == '0)); // R2

   AST_EJECT_HOME: assert property (@(posedge clk) disable iff (rst)
      ej_valid |-> (ej_flit[DX_HI:DX_LO] == X_W'(MY_X) &&
                    ej_flit[DY_HI:DY_LO] == Y_W'(MY_Y))); // R4

   logic any_home;
   always_comb begin
      any_home = 1'b0;
      for (int i = 0; i < NET_PORTS; i++)
         if (lat_v[i] && cand_want[i] == PORT_L) any_home = 1'b1;
   end

   AST_INJ_FULL: assert property (@(posedge clk) disable iff (rst)
      (&lat_v && !any_home) |-> !inj_accept); // R5
endmodule

// File: tb/rdr_deflect_router_tb.sv
`timescale 1ns/1ps
module rdr_deflect_router_tb;
   localparam int FW = 15;  // 2+2+3+8
   localparam int MX = 1;
   localparam int MY = 2;

   logic              clk = 1'b0;
   logic              rst;
   logic [3:0]        in_valid;
   logic [3:0][FW-1:0] in_flit;
   logic              inj_valid;
   logic [FW-1:0]     inj_flit;
   logic              inj_accept;
   logic [3:0]        out_valid;
   logic [3:0][FW-1:0] out_flit;
   logic              ej_valid;
   logic [FW-1:0]     ej_flit;

   always #2 clk = ~clk;

   rdr_deflect_router u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit),
      .inj_valid(inj_valid), .inj_flit(inj_flit), .inj_accept(inj_accept),
      .out_valid(out_valid), .out_flit(out_flit),
      .ej_valid(ej_valid), .ej_flit(ej_flit)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] seed = 32'h1234_5678;

   logic [4:0]        e_v;
   logic [4:0][FW-1:0] e_f;
   logic              e_acc;

   function automatic logic [FW-1:0] mk(int dx, int dy, int age, int pay);
      return {2'(dx), 2'(dy), 3'(age), 8'(pay)};
   endfunction

   function automatic int dir_of(logic [FW-1:0] f);
      int dx = int'(f[14:13]);
      int dy = int'(f[12:11]);
      if (dx > MX) return 1;
      if (dx < MX) return 3;
      if (dy > MY) return 0;
      if (dy < MY) return 2;
      return 4;
   endfunction

   function automatic logic [FW-1:0] bumped(logic [FW-1:0] f);
      logic [FW-1:0] r = f;
      if (f[10:8] != 3'd7) r[10:8] = f[10:8] + 3'd1;
      return r;
   endfunction

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   task automatic model(input logic [3:0] v, input logic [3:0][FW-1:0] f,
                        input logic iv, input logic [FW-1:0] ifl);
      int ord[4];
      int n = 0;
      logic [3:0] picked = '0;
      logic [3:0] done = '0;
      logic [4:0] busy = '0;
      e_v = '0; e_f = '0; e_acc = 1'b0;
      for (int k = 0; k < 4; k++) begin
         int best = -1;
         for (int i = 0; i < 4; i++)
            if (v[i] && !picked[i] && (best < 0 || f[i][10:8] > f[best][10:8])) best = i;
         if (best >= 0) begin ord[n] = best; n++; picked[best] = 1'b1; end
      end
      for (int k = 0; k < n; k++) begin
         int d = dir_of(f[ord[k]]);
         if (!busy[d]) begin
            busy[d] = 1'b1; done[ord[k]] = 1'b1;
            e_v[d] = 1'b1; e_f[d] = f[ord[k]];
         end
      end
      for (int k = 0; k < n; k++) begin
         if (!done[ord[k]]) begin
            for (int p = 0; p < 4; p++) begin
               if (!done[ord[k]] && !busy[p]) begin
                  busy[p] = 1'b1; done[ord[k]] = 1'b1;
                  e_v[p] = 1'b1; e_f[p] = bumped(f[ord[k]]);
               end
            end
         end
      end
      if (iv) begin
         int d = dir_of(ifl);
         if (d != 4 && !busy[d]) begin
            e_acc = 1'b1; e_v[d] = 1'b1; e_f[d] = ifl;
         end else begin
            for (int p = 0; p < 4; p++) begin
               if (!e_acc && !busy[p]) begin
                  busy[p] = 1'b1; e_acc = 1'b1; e_v[p] = 1'b1; e_f[p] = bumped(ifl);
               end
            end
         end
      end
   endtask

   task automatic chk(string tag, string what, logic [FW:0] act, logic [FW:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // called at a negedge; returns at a negedge two cycles later
   task automatic trial(string tag, input logic [3:0] v, input logic [3:0][FW-1:0] f,
                        input logic iv, input logic [FW-1:0] ifl);
      model(v, f, iv, ifl);
      in_valid = v; in_flit = f;
      @(negedge clk);
      in_valid = '0; in_flit = '0;
      inj_valid = iv; inj_flit = ifl;
      #1;
      chk(tag, "inj_accept", {15'd0, inj_accept}, {15'd0, e_acc});
      @(negedge clk);
      inj_valid = 1'b0; inj_flit = '0;
      for (int p = 0; p < 4; p++)
         chk(tag, $sformatf("out%0d", p), {out_valid[p], out_flit[p]},
             e_v[p] ? {1'b1, e_f[p]} : {1'b0, out_flit[p]});
      chk(tag, "eject", {ej_valid, ej_flit}, e_v[4] ? {1'b1, e_f[4]} : {1'b0, ej_flit});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [3:0][FW-1:0] f;
      rst = 1'b1; in_valid = '0; in_flit = '0; inj_valid = 1'b0; inj_flit = '0;
      repeat (3) @(negedge clk);
      // R8: reset keeps everything quiet even with an offered flit
      inj_valid = 1'b1; inj_flit = mk(3, 0, 0, 8'h11);
      #1;
      chk("R8", "inj_accept in reset", {15'd0, inj_accept}, 16'd0);
      chk("R8", "outputs in reset", {11'd0, ej_valid, out_valid}, 16'd0);
      @(negedge clk);
      inj_valid = 1'b0; inj_flit = '0;
      rst = 1'b0;
      @(negedge clk);
      chk("R8", "outputs after reset", {11'd0, ej_valid, out_valid}, 16'd0);

      // R1: one uncontested flit per direction
      f = '0; f[0] = mk(3, 2, 1, 8'hA1); trial("R1", 4'b0001, f, 1'b0, '0);
      f = '0; f[1] = mk(0, 3, 1, 8'hA2); trial("R1", 4'b0010, f, 1'b0, '0);
      f = '0; f[2] = mk(1, 3, 1, 8'hA3); trial("R1", 4'b0100, f, 1'b0, '0);
      f = '0; f[3] = mk(1, 0, 1, 8'hA4); trial("R1", 4'b1000, f, 1'b0, '0);
      f = '0; f[2] = mk(1, 2, 0, 8'hA5); trial("R4", 4'b0100, f, 1'b0, '0);

      // R3 and R6: all four want east; east input wins, others fill N,S,W
      f[0] = mk(3, 0, 2, 8'hB0); f[1] = mk(3, 1, 5, 8'hB1);
      f[2] = mk(2, 3, 5, 8'hB2); f[3] = mk(3, 3, 1, 8'hB3);
      trial("R3", 4'b1111, f, 1'b0, '0);
      n_chk++;
      if (out_flit[0] !== mk(2, 3, 6, 8'hB2)) begin
         n_fail++;
         $display("FAIL R6 out0 actual=%h expected=%h", out_flit[0], mk(2, 3, 6, 8'hB2));
      end

      // R4: two flits at home with equal age; south ejects, west deflects
      f = '0; f[2] = mk(1, 2, 3, 8'hC2); f[3] = mk(1, 2, 3, 8'hC3);
      trial("R4", 4'b1100, f, 1'b0, '0);

      // R7: saturated age stays at maximum when deflected
      f = '0; f[0] = mk(3, 2, 7, 8'hD0); f[1] = mk(3, 2, 7, 8'hD1);
      trial("R7", 4'b0011, f, 1'b0, '0);

      // R5: full router refuses, three flits leave room
      f[0] = mk(0, 0, 1, 8'hE0); f[1] = mk(2, 0, 1, 8'hE1);
      f[2] = mk(1, 3, 1, 8'hE2); f[3] = mk(1, 0, 1, 8'hE3);
      trial("R5", 4'b1111, f, 1'b1, mk(3, 3, 0, 8'hEE));
      trial("R5", 4'b0111, f, 1'b1, mk(3, 3, 0, 8'hEF));
      trial("R5", 4'b1101, f, 1'b1, mk(1, 3, 0, 8'hF0));

      // R2: pseudo-random sweep across the 4x4 mesh
      for (int t = 0; t < 3000; t++) begin
         logic [3:0] v;
         logic iv;
         logic [FW-1:0] ifl;
         logic [31:0] r;
         v = rnd()[3:0];
         for (int i = 0; i < 4; i++) begin
            r = rnd();
            f[i] = mk(int'(r[1:0]), int'(r[3:2]), int'(r[6:4]) % 4 + ((t % 7 == 0) ? 4 : 0),
                      int'(r[15:8]));
         end
         r = rnd();
         iv = r[0];
         ifl = mk(int'(r[2:1]), int'(r[4:3]), 0, int'(r[15:8]));
         if (int'(r[2:1]) == MX && int'(r[4:3]) == MY) ifl[14:13] = 2'd3;
         trial("R2", v, f, iv, ifl);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule